// File: doc/BRIEF.md
# Event Status Register with Error Capture

This block keeps an 8-bit register of sticky event flags, an 8-bit enable mask for those flags, and a register that holds the code of the most recent command execution error. Event sources raise flags with single-cycle set pulses. A read of the event register returns all flags and clears them. A read of the error register returns the stored code and clears it. Writing the mask loads a new enable pattern, and the mask can be read back at any time.

A single summary output is high whenever some flag is set and its enable bit is also set. An accepted error code also raises flag 4, so an error reaches the summary unless bit 4 of the mask is clear. Each host interface instantiates its own copy. All read data is taken straight from the registers. A write, a set pulse or a read-clear shows up on the outputs after the next rising clock edge.

Top module: `evt_status_unit`

## Requirements
- R1: After reset the mask reads 0. A mask write with any value from 0 to 255 is returned unchanged on `mask_o` from the next cycle until the next write.
- R2: After reset the event register reads 0. A set pulse on bit k makes bit k read 1 from the next cycle. Without a read, the bit stays 1 while later pulses set more bits.
- R3: In a cycle with `evt_rd_i` high, `evt_rdata_o` shows the current flags. From the next cycle every flag not set again in that cycle reads 0.
- R4: A set pulse, or an accepted error, in the same cycle as an event read leaves its flag set after the clear.
- R5: `summary_o` is 1 exactly when the bitwise AND of the event register and the mask is nonzero.
- R6: After reset the error register reads 0. An error report with code 100, 101, 102, 103 or 200 is stored from the next cycle and replaces any earlier code.
- R7: In a cycle with `err_rd_i` high, `err_rdata_o` shows the stored code, and the register reads 0 from the next cycle. An accepted report in the same cycle is stored instead of the clear.
- R8: An accepted error sets event bit 4 from the next cycle. No other mask applies to it, so only mask bit 4 can keep it out of `summary_o`.
- R9: An error report with any other code, including 0, leaves both the error register and the event register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_set_i | input | 8 | Single-cycle set pulses, one per event flag |
| evt_rd_i | input | 1 | Event register read; clears the flags after this cycle |
| evt_rdata_o | output | 8 | Current event flags |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write value |
| mask_o | output | 8 | Current enable mask |
| err_valid_i | input | 1 | Error report strobe |
| err_code_i | input | 8 | Reported error code |
| err_rd_i | input | 1 | Error register read; clears the code after this cycle |
| err_rdata_o | output | 8 | Stored error code |
| summary_o | output | 1 | High when any enabled event flag is set |

## Verification
Every registered result is due exactly one edge after its stimulus: the mask after a write, a flag after a set pulse or an accepted error, a clear after a read, and a new code after a report. `summary_o` follows the registers in that same cycle without an extra delay. The bench applies inputs just after a rising edge. It advances a behavioural model at that edge and compares every output one time unit later, so each result is checked in the first cycle it is due. The stimulus also places reads and reports in the same cycle to check that the new value is kept.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int unsigned EVT_W       = 8;
  localparam int unsigned ERR_W       = 8;
  localparam int unsigned ERR_EVT_BIT = 4;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE      = 8'd0,
    ERR_ENABLE    = 8'd100,
    ERR_NUMERIC   = 8'd101,
    ERR_INTERRUPT = 8'd102,
    ERR_RECALL    = 8'd103,
    ERR_ACCESS    = 8'd200
  } err_code_e;

  function automatic logic err_code_known(logic [ERR_W-1:0] c);
    return (c == ERR_ENABLE)    || (c == ERR_NUMERIC) ||
           (c == ERR_INTERRUPT) || (c == ERR_RECALL)  ||
           (c == ERR_ACCESS);
  endfunction
endpackage

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

  // R1
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i));

  // R1
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/evt_flag_reg.sv
module evt_flag_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  // new sets win over the read-clear
  always_comb q_d = (rd_i ? '0 : q_o) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  // R2
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (q_o & $past(q_o)) == $past(q_o));

  // R4
  flag_set_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> (q_o & $past(set_i)) == $past(set_i));

  // R3
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && set_i == '0) |=> q_o == '0);
endmodule

// File: rtl/err_code_reg.sv
module err_code_reg
  import evt_status_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rep_valid_i,
  input  logic [ERR_W-1:0] rep_code_i,
  input  logic             rd_i,
  output logic [ERR_W-1:0] code_o,
  output logic             accept_o
);
  always_comb accept_o = rep_valid_i && err_code_known(rep_code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_o <= ERR_NONE;
    else if (accept_o) code_o <= rep_code_i;
    else if (rd_i)     code_o <= ERR_NONE;
  end

  // R9
  err_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_valid_i && !err_code_known(rep_code_i) && !rd_i) |=> $stable(code_o));

  // R7
  err_rdclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rep_valid_i) |=> code_o == ERR_NONE);

  // R6
  err_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o == ERR_NONE || err_code_known(code_o));
endmodule

// File: rtl/evt_status_unit.sv
module evt_status_unit
  import evt_status_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_set_i,
  input  logic             evt_rd_i,
  output logic [EVT_W-1:0] evt_rdata_o,
  input  logic             mask_we_i,
  input  logic [EVT_W-1:0] mask_wdata_i,
  output logic [EVT_W-1:0] mask_o,
  input  logic             err_valid_i,
  input  logic [ERR_W-1:0] err_code_i,
  input  logic             err_rd_i,
  output logic [ERR_W-1:0] err_rdata_o,
  output logic             summary_o
);
  logic             err_accept;
  logic [EVT_W-1:0] evt_set_all;

  err_code_reg u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rep_valid_i(err_valid_i),
    .rep_code_i (err_code_i),
    .rd_i       (err_rd_i),
    .code_o     (err_rdata_o),
    .accept_o   (err_accept)
  );

  always_comb begin
    evt_set_all = evt_set_i;
    evt_set_all[ERR_EVT_BIT] = evt_set_i[ERR_EVT_BIT] | err_accept;
  end

  evt_flag_reg #(.W(EVT_W)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_set_all),
    .rd_i  (evt_rd_i),
    .q_o   (evt_rdata_o)
  );

  evt_mask_reg #(.W(EVT_W)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we_i),
    .wdata_i(mask_wdata_i),
    .q_o    (mask_o)
  );

  always_comb summary_o = |(evt_rdata_o & mask_o);

  // R8
  err_sets_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && err_code_known(err_code_i)) |=> evt_rdata_o[ERR_EVT_BIT]);

  // R5
  summary_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_set_i & mask_o) != '0 && !mask_we_i) |=> summary_o);
endmodule

// File: tb/tb_evt_status_unit.sv
module tb_evt_status_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] evt_set_i = '0;
  logic       evt_rd_i = 1'b0;
  logic [7:0] evt_rdata_o;
  logic       mask_we_i = 1'b0;
  logic [7:0] mask_wdata_i = '0;
  logic [7:0] mask_o;
  logic       err_valid_i = 1'b0;
  logic [7:0] err_code_i = '0;
  logic       err_rd_i = 1'b0;
  logic [7:0] err_rdata_o;
  logic       summary_o;

  int n_chk = 0, n_err = 0;
  int m_evt = 0, m_mask = 0, m_err = 0;
  string tag = "R1";

  always #5 clk_i = ~clk_i;

  evt_status_unit dut (.*);

  task automatic check(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic compare_all();
    check({tag, " evt"},     evt_rdata_o, m_evt);
    check({tag, " mask"},    mask_o, m_mask);
    check({tag, " err"},     err_rdata_o, m_err);
    check({tag, " summary"}, summary_o, ((m_evt & m_mask) != 0) ? 1 : 0);
  endtask

  function automatic bit known(int c);
    return c == 100 || c == 101 || c == 102 || c == 103 || c == 200;
  endfunction

  // one clock: apply inputs, advance model at the edge, compare after it
  task automatic cyc(int set, bit erd, bit mwe, int mw, bit ev, int ec, bit rrd);
    bit acc;
    evt_set_i = set[7:0]; evt_rd_i = erd; mask_we_i = mwe; mask_wdata_i = mw[7:0];
    err_valid_i = ev; err_code_i = ec[7:0]; err_rd_i = rrd;
    @(posedge clk_i);
    acc = ev && known(ec);
    m_evt  = ((erd ? 0 : m_evt) | set | (acc ? 16 : 0)) & 255;
    m_mask = mwe ? mw : m_mask;
    m_err  = acc ? ec : (rrd ? 0 : m_err);
    #1;
    compare_all();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #1_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int lfsr = 16'hACE1;
    repeat (3) @(posedge clk_i);
    #1;
    tag = "R1_R2_R6 reset"; compare_all();
    rst_ni = 1'b1;
    idle();
    // R1 mask writes and hold
    tag = "R1";
    cyc(0, 0, 1, 255, 0, 0, 0); idle();
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 1, 8'hA5, 0, 0, 0); idle(); idle();
    // R2 sticky set pulses, R5 summary via mask A5
    tag = "R2";
    cyc(8'h02, 0, 0, 0, 0, 0, 0); idle();
    cyc(8'h01, 0, 0, 0, 0, 0, 0); idle();
    tag = "R5";
    cyc(8'h80, 0, 0, 0, 0, 0, 0); idle();
    cyc(0, 0, 1, 8'h02, 0, 0, 0);
    cyc(0, 0, 1, 8'h40, 0, 0, 0);
    // R3 read-clear
    tag = "R3";
    cyc(0, 1, 0, 0, 0, 0, 0); idle();
    // R4 read with simultaneous set
    tag = "R4";
    cyc(8'h0F, 0, 0, 0, 0, 0, 0);
    cyc(8'h40, 1, 0, 0, 0, 0, 0); idle();
    cyc(0, 1, 0, 0, 0, 0, 0);
    // R6 capture each code, latest wins; R8 bit 4
    tag = "R6";
    cyc(0, 0, 1, 8'hFF, 100, 0, 0);
    cyc(0, 0, 0, 0, 1, 100, 0);
    cyc(0, 0, 0, 0, 1, 101, 0);
    cyc(0, 0, 0, 0, 1, 102, 0);
    cyc(0, 0, 0, 0, 1, 103, 0);
    cyc(0, 0, 0, 0, 1, 200, 0); idle();
    // R7 read-clear and collision
    tag = "R7";
    cyc(0, 0, 0, 0, 0, 0, 1); idle();
    cyc(0, 0, 0, 0, 1, 101, 0);
    cyc(0, 0, 0, 0, 1, 103, 1); idle();
    cyc(0, 0, 0, 0, 0, 0, 1);
    // R8 bit 4 masked only by mask bit 4, even across event read
    tag = "R8";
    cyc(0, 1, 1, 8'hEF, 0, 0, 0);
    cyc(0, 1, 0, 0, 1, 102, 0); idle();
    cyc(0, 0, 1, 8'h10, 0, 0, 0); idle();
    // R9 unknown codes ignored
    tag = "R9";
    cyc(0, 1, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 99, 0);
    cyc(0, 0, 0, 0, 1, 104, 0);
    cyc(0, 0, 0, 0, 1, 255, 0);
    cyc(0, 0, 0, 0, 1, 200, 0);
    cyc(0, 0, 0, 0, 1, 150, 0); idle();
    // mixed traffic covering R2 R3 R4 R5 R6 R7 R8 R9
    tag = "R5_mixed";
    for (int i = 0; i < 400; i++) begin
      int codes[8] = '{0, 100, 101, 102, 103, 200, 77, 201};
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0);
      cyc((lfsr[3:0] == 0) ? (1 << lfsr[6:4]) : 0,
          lfsr[9:7] == 0, lfsr[12:10] == 0, lfsr[7:0] ^ lfsr[15:8],
          lfsr[14:13] == 0, codes[lfsr[5:3]], lfsr[15:14] == 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule